// File: doc/BRIEF.md
# Boot Region Command Sequencer

This block watches host writes that fall into two small address windows of a flash interface's boot buffer and interprets the written value as a boot command. Three commands are understood. A warm-reset command asks an external reset controller to act. An identification command writes three identification words into the boot buffer. An arming command opens a two-write load sequence. The write that follows the arming command always ends the sequence. If that write carries zero, a one-page load into the first data buffer is requested.

The block owns the page address register. After every load it steps that register by four and keeps it within eight bits, so consecutive loads walk through the pages of a block. The page-load engine and the buffer RAM sit outside the block. A one-cycle request port reaches the engine, and a word-write port reaches the RAM. All outputs are registered and appear one clock after the write that causes them.

Top module: `bootseq_top`

## Requirements
- R1: Only writes whose word address lies in 0x0000..0x01FF or 0x8000..0x800F are commands (0x01FF and 0x800F inside, 0x0200 and 0x8010 outside). Writes anywhere else leave `armed` unchanged and raise no request.
- R2: While not armed, a window write of 0x00F0 makes `rstReq` high for exactly the one cycle after the write, and `armed` stays low.
- R3: While not armed, a window write of 0x00E0 sets `armed` in the cycle after the write.
- R4: While armed, a window write of 0x0000 makes `loadReq` high for exactly one cycle after the write. During that cycle `loadBlock` equals `blockAddr` and `loadPage` equals the page register before it steps, and `armed` is low.
- R5: While armed, a window write of any nonzero value clears `armed`. It raises no load, no reset and no buffer write, even for 0x00F0, 0x00E0 or 0x0090.
- R6: Each load sets the page register to (old value + 4) AND 0x00FF. For example, 0x00FC becomes 0x0000 and 0x01F0 becomes 0x00F4.
- R7: While not armed, a window write of 0x0090 produces buffer writes on three consecutive cycles, starting the cycle after the write. Word 0 holds {0x00, manufacturer ID bits 7:0}, word 1 holds {0x00, device ID bits 7:0}, and word 2 holds {0x00, protection status bits 7:0}. `bufWrEn` falls in the cycle after that.
- R8: While not armed, a window write of any value other than 0x00F0, 0x00E0 and 0x0090 changes nothing.
- R9: After reset, `armed`, `loadReq`, `rstReq` and `bufWrEn` are low and the page register is 0x0000.
- R10: `pageSetEn` loads `pageSetVal` into the page register on the next edge. It takes priority over the step of R6 when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 16 | Host write word address |
| wrData | input | 16 | Host write value |
| blockAddr | input | 16 | Current block address register |
| pageSetEn | input | 1 | Load strobe for the page register |
| pageSetVal | input | 16 | Value for the page register |
| mfrId | input | 16 | Manufacturer identification |
| devId | input | 16 | Device identification |
| protStat | input | 16 | Write-protection status |
| armed | output | 1 | Second-cycle state of the load sequence |
| pageAddr | output | 16 | Page address register |
| loadReq | output | 1 | One-cycle page-load request |
| loadBlock | output | 16 | Block address carried by the load request |
| loadPage | output | 16 | Page address carried by the load request |
| rstReq | output | 1 | One-cycle warm-reset request |
| bufWrEn | output | 1 | Boot-buffer word write enable |
| bufWrAddr | output | 2 | Boot-buffer word index |
| bufWrData | output | 16 | Boot-buffer word value |

## Verification
The properties assume the host issues at most one write per cycle. They also assume `blockAddr` and the identification inputs are stable around a command. The page-step property assumes the page register is not loaded in the cycle of a load. The single-cycle load-pulse property relies on arming and triggering always taking two separate writes. The stimulus drives each write for a single cycle and keeps the other inputs constant across a command. It loads the page register either alone or deliberately together with a trigger, and the step property is masked off in the combined case.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;
  localparam int AddrW   = 16;
  localparam int DataW   = 16;
  localparam int NumWin  = 2;
  localparam int IdWords = 3;
  localparam int IdxW    = $clog2(IdWords + 1);
  localparam int ByteW   = 8;

  localparam logic [AddrW-1:0] WinLo [NumWin] = '{16'h0000, 16'h8000};
  localparam logic [AddrW-1:0] WinHi [NumWin] = '{16'h01FF, 16'h800F};

  localparam logic [DataW-1:0] CmdReset   = 16'h00F0;
  localparam logic [DataW-1:0] CmdArm     = 16'h00E0;
  localparam logic [DataW-1:0] CmdIdent   = 16'h0090;
  localparam logic [DataW-1:0] TriggerVal = 16'h0000;

  typedef struct packed {
    logic doReset;
    logic doLoad;
    logic doIdent;
  } strobe_t;
endpackage

// File: rtl/bootseq_ctrl.sv
module bootseq_ctrl
  import bootseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [DataW-1:0] wrData,
  output strobe_t          strb,
  output logic             armed
);
  logic [NumWin-1:0] winHit;
  logic              cmdWrite;
  logic              armedNext;

  // One comparator per window; subtract-and-compare avoids a >= 0 test
  for (genvar g = 0; g < NumWin; g++) begin : g_win
    assign winHit[g] = (wrAddr - WinLo[g]) <= (WinHi[g] - WinLo[g]);
  end

  assign cmdWrite = wrEn && (|winHit);

  always_comb begin
    strb      = '0;
    armedNext = armed;
    if (cmdWrite) begin
      if (armed) begin
        armedNext   = 1'b0;
        strb.doLoad = (wrData == TriggerVal);
      end else begin
        case (wrData)
          CmdReset: begin
            strb.doReset = 1'b1;
            armedNext    = 1'b0;
          end
          CmdArm:   armedNext    = 1'b1;
          CmdIdent: strb.doIdent = 1'b1;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armedNext;
  end
endmodule

// File: rtl/bootseq_dpath.sv
module bootseq_dpath
  import bootseq_pkg::*;
#(
  parameter int PageStep = 4,
  parameter int PageBits = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [DataW-1:0] blockAddr,
  input  logic             pageSetEn,
  input  logic [DataW-1:0] pageSetVal,
  input  logic [DataW-1:0] mfrId,
  input  logic [DataW-1:0] devId,
  input  logic [DataW-1:0] protStat,
  output logic [DataW-1:0] pageAddr,
  output logic             loadReq,
  output logic [DataW-1:0] loadBlock,
  output logic [DataW-1:0] loadPage,
  output logic             rstReq,
  output logic             bufWrEn,
  output logic [1:0]       bufWrAddr,
  output logic [DataW-1:0] bufWrData
);
  localparam logic [DataW-1:0] StepV    = DataW'(PageStep);
  localparam logic [DataW-1:0] PageMask = DataW'((1 << PageBits) - 1);
  localparam logic [IdxW-1:0]  LastIdx  = IdxW'(IdWords - 1);

  logic [IdWords-1:0][DataW-1:0] idSrc;
  logic [DataW-1:0]              idWord [IdWords];
  logic [IdxW-1:0]               idNext;
  logic                          idBusy;

  assign idSrc = {protStat, devId, mfrId};

  for (genvar g = 0; g < IdWords; g++) begin : g_id
    assign idWord[g] = {{(DataW-ByteW){1'b0}}, idSrc[g][ByteW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pageAddr  <= '0;
      loadReq   <= 1'b0;
      loadBlock <= '0;
      loadPage  <= '0;
      rstReq    <= 1'b0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
      idNext    <= '0;
      idBusy    <= 1'b0;
    end else begin
      loadReq <= strb.doLoad;
      rstReq  <= strb.doReset;
      if (strb.doLoad) begin
        loadBlock <= blockAddr;
        loadPage  <= pageAddr;
      end
      if (pageSetEn)        pageAddr <= pageSetVal;
      else if (strb.doLoad) pageAddr <= (pageAddr + StepV) & PageMask;

      if (strb.doIdent) begin
        bufWrEn   <= 1'b1;
        bufWrAddr <= '0;
        bufWrData <= idWord[0];
        idNext    <= IdxW'(1);
        idBusy    <= 1'b1;
      end else if (idBusy) begin
        bufWrEn   <= 1'b1;
        bufWrAddr <= 2'(idNext);
        bufWrData <= idWord[idNext];
        idNext    <= idNext + 1'b1;
        if (idNext == LastIdx) idBusy <= 1'b0;
      end else begin
        bufWrEn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bootseq_top.sv
module bootseq_top
  import bootseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic [15:0] wrData,
  input  logic [15:0] blockAddr,
  input  logic        pageSetEn,
  input  logic [15:0] pageSetVal,
  input  logic [15:0] mfrId,
  input  logic [15:0] devId,
  input  logic [15:0] protStat,
  output logic        armed,
  output logic [15:0] pageAddr,
  output logic        loadReq,
  output logic [15:0] loadBlock,
  output logic [15:0] loadPage,
  output logic        rstReq,
  output logic        bufWrEn,
  output logic [1:0]  bufWrAddr,
  output logic [15:0] bufWrData
);
  strobe_t strb;

  bootseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strb(strb), .armed(armed)
  );

  bootseq_dpath #(.PageStep(4), .PageBits(8)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .blockAddr(blockAddr),
    .pageSetEn(pageSetEn), .pageSetVal(pageSetVal), .mfrId(mfrId),
    .devId(devId), .protStat(protStat), .pageAddr(pageAddr),
    .loadReq(loadReq), .loadBlock(loadBlock), .loadPage(loadPage),
    .rstReq(rstReq), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr),
    .bufWrData(bufWrData)
  );
endmodule

// File: rtl/bootseq_checker.sv
module bootseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic [15:0] wrAddr,
  input logic [15:0] wrData,
  input logic        pageSetEn,
  input logic        armed,
  input logic [15:0] pageAddr,
  input logic        loadReq,
  input logic [15:0] loadPage,
  input logic        rstReq,
  input logic        bufWrEn,
  input logic [1:0]  bufWrAddr,
  input logic [15:0] bufWrData
);
  logic inWin;
  logic prevSet;
  logic prevArmCmd;

  assign inWin = (wrAddr <= 16'h01FF) ||
                 ((wrAddr >= 16'h8000) && (wrAddr <= 16'h800F));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevSet    <= 1'b0;
      prevArmCmd <= 1'b0;
    end else begin
      prevSet    <= pageSetEn;
      prevArmCmd <= wrEn && inWin && (wrData == 16'h00E0) && !armed;
    end
  end

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !inWin) |=> (armed == $past(armed)) && !loadReq && !rstReq); // R1
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |-> !armed && !$past(armed)); // R2
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    prevArmCmd |-> armed); // R3
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    loadReq |=> !loadReq); // R4
  AST_LOAD_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    loadReq |-> !armed && $past(armed)); // R4
  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wrEn && inWin) |=> !armed); // R5
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (loadReq && !prevSet) |-> pageAddr == ((loadPage + 16'd4) & 16'h00FF)); // R6
  AST_ID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (bufWrEn && bufWrAddr != 2'd0) |-> $past(bufWrEn) && (bufWrAddr == $past(bufWrAddr) + 2'd1)); // R7
  AST_ID_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrEn |-> bufWrData[15:8] == 8'h00); // R7
endmodule

bind bootseq_top bootseq_checker u_chk (.*);

// File: tb/bootseq_top_tb.sv
`timescale 1ns/1ps
module bootseq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0, wrData = '0;
  logic [15:0] blockAddr = 16'h0123;
  logic        pageSetEn = 1'b0;
  logic [15:0] pageSetVal = '0;
  logic [15:0] mfrId = 16'hABEC, devId = 16'h5A25, protStat = 16'h0302;
  logic        armed, loadReq, rstReq, bufWrEn;
  logic [15:0] pageAddr, loadBlock, loadPage, bufWrData;
  logic [1:0]  bufWrAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] pageModel = '0;

  always #2 clk = ~clk;

  bootseq_top u_dut (.*);

  // addr, data, exp armed, exp loadReq, exp rstReq, exp bufWrEn
  localparam logic [35:0] VEC [15] = '{
    {16'h0200, 16'h00E0, 4'b0000},  // R1 just above first window
    {16'h8010, 16'h00E0, 4'b0000},  // R1 just above second window
    {16'h01FF, 16'h00E0, 4'b1000},  // R3 top of first window
    {16'h4000, 16'h0000, 4'b1000},  // R1 outside, stays armed
    {16'h800F, 16'h0000, 4'b0100},  // R4 trigger in second window
    {16'h8000, 16'h00E0, 4'b1000},  // R3
    {16'h0000, 16'h00F0, 4'b0000},  // R5 reset value only disarms
    {16'h0010, 16'h00F0, 4'b0010},  // R2
    {16'h0000, 16'h1234, 4'b0000},  // R8
    {16'h0000, 16'h00E0, 4'b1000},  // R3
    {16'h0004, 16'h00E0, 4'b0000},  // R5 arm value disarms
    {16'h0000, 16'h00E0, 4'b1000},  // R3
    {16'h0000, 16'h0090, 4'b0000},  // R5 ident value disarms
    {16'h7FFF, 16'h00F0, 4'b0000},  // R1 outside
    {16'h0000, 16'h00E1, 4'b0000}   // R8
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one write for one cycle; returns at the negedge after the capturing edge
  task automatic doWrite(input logic [15:0] a, input logic [15:0] d, input bit setPg, input logic [15:0] pv);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    pageSetEn = setPg; pageSetVal = pv;
    @(negedge clk);
    wrEn = 1'b0; pageSetEn = 1'b0;
  endtask

  task automatic setPage(input logic [15:0] v);
    @(negedge clk);
    pageSetEn = 1'b1; pageSetVal = v;
    @(negedge clk);
    pageSetEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!armed && !loadReq && !rstReq && !bufWrEn, "R9 reset outputs",
          {armed, loadReq, rstReq, bufWrEn}, 0);
    check(pageAddr == 16'h0000, "R9 reset page", pageAddr, 0);

    // table walk
    for (int i = 0; i < 15; i++) begin
      doWrite(VEC[i][35:20], VEC[i][19:4], 1'b0, 16'h0);
      check({armed, loadReq, rstReq, bufWrEn} == VEC[i][3:0],
            $sformatf("R1/R2/R3/R4/R5/R8 vector %0d", i),
            {armed, loadReq, rstReq, bufWrEn}, VEC[i][3:0]);
      if (VEC[i][2]) begin
        check(loadPage == pageModel && loadBlock == blockAddr, "R4 load address",
              {loadBlock, loadPage}, {blockAddr, pageModel});
        pageModel = (pageModel + 16'd4) & 16'h00FF;
        check(pageAddr == pageModel, "R6 page step", pageAddr, pageModel);
      end
    end

    // R4/R2 pulses last one cycle
    doWrite(16'h0000, 16'h00E0, 1'b0, 16'h0);
    doWrite(16'h0000, 16'h0000, 1'b0, 16'h0);
    check(loadReq, "R4 load pulse high", loadReq, 1);
    @(negedge clk);
    check(!loadReq, "R4 load pulse drops", loadReq, 0);
    doWrite(16'h8001, 16'h00F0, 1'b0, 16'h0);
    check(rstReq, "R2 reset pulse high", rstReq, 1);
    @(negedge clk);
    check(!rstReq, "R2 reset pulse drops", rstReq, 0);

    // R6 wrap from 0xFC
    setPage(16'h00FC);
    check(pageAddr == 16'h00FC, "R10 page set", pageAddr, 16'h00FC);
    doWrite(16'h0000, 16'h00E0, 1'b0, 16'h0);
    doWrite(16'h0000, 16'h0000, 1'b0, 16'h0);
    check(loadPage == 16'h00FC, "R6 wrap carried page", loadPage, 16'h00FC);
    check(pageAddr == 16'h0000, "R6 wrap to zero", pageAddr, 0);

    // R6 upper bits dropped
    setPage(16'h01F0);
    doWrite(16'h0000, 16'h00E0, 1'b0, 16'h0);
    doWrite(16'h8002, 16'h0000, 1'b0, 16'h0);
    check(loadPage == 16'h01F0, "R6 carried page", loadPage, 16'h01F0);
    check(pageAddr == 16'h00F4, "R6 mask to 8 bits", pageAddr, 16'h00F4);

    // R10 set wins over step
    doWrite(16'h0000, 16'h00E0, 1'b0, 16'h0);
    doWrite(16'h0000, 16'h0000, 1'b1, 16'h0040);
    check(loadReq && loadPage == 16'h00F4, "R10 load carries old page", loadPage, 16'h00F4);
    check(pageAddr == 16'h0040, "R10 set priority", pageAddr, 16'h0040);

    // R7 identification burst
    doWrite(16'h8003, 16'h0090, 1'b0, 16'h0);
    check(bufWrEn && bufWrAddr == 2'd0 && bufWrData == 16'h00EC, "R7 word0",
          {bufWrEn, bufWrAddr, bufWrData}, {1'b1, 2'd0, 16'h00EC});
    @(negedge clk);
    check(bufWrEn && bufWrAddr == 2'd1 && bufWrData == 16'h0025, "R7 word1",
          {bufWrEn, bufWrAddr, bufWrData}, {1'b1, 2'd1, 16'h0025});
    @(negedge clk);
    check(bufWrEn && bufWrAddr == 2'd2 && bufWrData == 16'h0002, "R7 word2",
          {bufWrEn, bufWrAddr, bufWrData}, {1'b1, 2'd2, 16'h0002});
    @(negedge clk);
    check(!bufWrEn, "R7 burst ends", bufWrEn, 0);
    check(!armed && !loadReq && !rstReq, "R7 no side effects",
          {armed, loadReq, rstReq}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule